// File: doc/BRIEF.md
# Memory Self-Test Failure Logger with Skip Count

This block sits beside a memory self-test sequencer and watches the outcome of every checked access in a test pass. Each access arrives with a valid strobe, a miscompare bit, the address that was tested and the data that was read back. The block keeps a sticky fail flag and stores the address and data of failures in a four-entry log. It also stops the pass at the first failure when the halt-on-error control is set.

A programmable skip count leaves the first N failures of a pass out of the log. Software runs a pass, reads the log, adds the number of entries it collected to the skip count and starts again. In this way it can gather an unlimited list of failures four at a time. The fail flag and the halt decision do not depend on the skip count. A count of valid entries is exposed, so an empty slot can be told apart from a real failure at address 0 that read back zero data.

The controller has four states. IDLE is the state after reset. RUN accepts accesses. FINISHED is entered after the last access of a pass. HALTED is entered on a failure while halt-on-error is set. The transitions are:
- start: from any state to RUN.
- end-of-pass: RUN to FINISHED, on an accepted access marked last that does not halt.
- halt-taken: RUN to HALTED, on an accepted failing access while halt-on-error is 1.

FINISHED and HALTED are left only by start.

Top module: `mbist_fail_log`

## Requirements
- R1: A start pulse clears the fail flag, the valid-entry count, the running failure index and every log entry, drops done and halted one cycle later, and leaves the skip count untouched.
- R2: The fail flag goes to 1 one cycle after any accepted failing access, whatever the skip count, and stays at 1 until the next start.
- R3: Failures are numbered from 0 in the order they are accepted. A failure whose number is below the skip count is not logged. Log entry k holds failure number skip+k.
- R4: Each log entry holds the address and the data of its failure. They are read on rd_addr and rd_data when rd_sel equals the entry number. An entry that was never filled reads back as zero.
- R5: log_count equals the number of filled entries, from 0 to 4, and grows by at most one per cycle.
- R6: Once all four entries are filled, later failures still set the fail flag but change no entry.
- R7: With halt_en at 1, the first accepted failure moves the block to HALTED, whatever the skip count. halted and done read 1 in the next cycle. That failure is logged only when the skip count is 0.
- R8: With halt_en at 0, the pass continues past failures. done reads 1 in the cycle after the access marked acc_last is accepted, and halted stays 0.
- R9: After done, accesses are ignored until the next start: fail, log_count and the entries keep their values.
- R10: A cycle with acc_valid at 0 changes no fail flag, count, entry or state, whatever acc_fail, acc_addr and acc_data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a pass |
| halt_en | input | 1 | 1 = stop at the first failure, 0 = continue |
| skip_cnt | input | IDX_W (16) | Number of leading failures kept out of the log |
| acc_valid | input | 1 | An access result is presented this cycle |
| acc_fail | input | 1 | The presented access miscompared |
| acc_last | input | 1 | The presented access is the last of the pass |
| acc_addr | input | ADDR_W (16) | Address of the presented access |
| acc_data | input | DATA_W (16) | Data observed for the presented access |
| rd_sel | input | SEL_W (2) | Log entry selected for reading |
| fail | output | 1 | Sticky failure flag |
| done | output | 1 | Pass has ended (FINISHED or HALTED) |
| halted | output | 1 | Pass was stopped by a failure |
| log_count | output | CNT_W (3) | Number of filled log entries |
| rd_addr | output | ADDR_W (16) | Address stored in the selected entry |
| rd_data | output | DATA_W (16) | Data stored in the selected entry |

## Verification
The bench sweeps every skip count from 0 to 6 against six failure masks over a twelve-access pass:
- No failure at all, which separates a clean pass from a failing one.
- A single failure at either end of the pass.
- Failures on every access, which tell whether a full log is overwritten.
- Two sparse patterns, which show whether the skip index counts failures or accesses.

Each mask is run with ascending and with descending addresses, and with halt-on-error both off and on. The descending runs end on a failure at address 0 with zero data, which is told apart from an empty slot only by log_count. After every access the bench compares done, halted and fail with its own model. This pins the halt to the right cycle and shows that the skip count has no effect on it. Invalid cycles that carry a miscompare and junk data are mixed into the stream. Accesses that keep arriving after the pass has ended test that they are ignored.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_FINISHED = 2'd2,
        ST_HALTED   = 2'd3
    } mbl_state_e;

endpackage

// File: rtl/mbl_ctrl.sv
module mbl_ctrl
    import mbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       halt_en,
    input  logic       acc_valid,
    input  logic       acc_fail,
    input  logic       acc_last,
    output mbl_state_e st,
    output logic       take,
    output logic       done,
    output logic       halted
);

    mbl_state_e st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // transitions: start, end-of-pass, halt-taken
    always_comb begin
        st_nxt = st;
        if (start) begin
            st_nxt = ST_RUN;
        end else begin
            unique case (st)
                ST_IDLE:     st_nxt = ST_IDLE;
                ST_RUN: begin
                    if (acc_valid && acc_fail && halt_en) begin
                        st_nxt = ST_HALTED;
                    end else if (acc_valid && acc_last) begin
                        st_nxt = ST_FINISHED;
                    end
                end
                ST_FINISHED: st_nxt = ST_FINISHED;
                ST_HALTED:   st_nxt = ST_HALTED;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        take   = 1'b0;
        done   = 1'b0;
        halted = 1'b0;
        unique case (st)
            ST_IDLE:     ;
            ST_RUN:      take = acc_valid && !start;
            ST_FINISHED: done = 1'b1;
            ST_HALTED: begin
                done   = 1'b1;
                halted = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mbl_skip_cnt.sv
module mbl_skip_cnt #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic [IDX_W-1:0] skip,
    output logic             log_ok
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx;

    // running failure index, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (hit && idx != IDX_MAX) begin
            idx <= idx + 1'b1;
        end
    end

    assign log_ok = (idx >= skip);

endmodule

// File: rtl/mbl_log_bank.sv
module mbl_log_bank #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int SEL_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic              room;

    assign room = (count != CNT_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr && room) begin
            count <= count + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_addr[g] <= '0;
                ent_data[g] <= '0;
            end else if (clr) begin
                ent_addr[g] <= '0;
                ent_data[g] <= '0;
            end else if (wr && room && count == CNT_W'(g)) begin
                ent_addr[g] <= wr_addr;
                ent_data[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_addr = '0;
        rd_data = '0;
        if (32'(rd_sel) < DEPTH) begin
            rd_addr = ent_addr[rd_sel];
            rd_data = ent_data[rd_sel];
        end
    end

endmodule

// File: rtl/mbist_fail_log.sv
module mbist_fail_log
    import mbl_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int SEL_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt_en,
    input  logic [IDX_W-1:0]  skip_cnt,
    input  logic              acc_valid,
    input  logic              acc_fail,
    input  logic              acc_last,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              fail,
    output logic              done,
    output logic              halted,
    output logic [CNT_W-1:0]  log_count,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    mbl_state_e st;
    logic       take;
    logic       hit;
    logic       log_ok;

    mbl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .halt_en   (halt_en),
        .acc_valid (acc_valid),
        .acc_fail  (acc_fail),
        .acc_last  (acc_last),
        .st        (st),
        .take      (take),
        .done      (done),
        .halted    (halted)
    );

    assign hit = take && acc_fail;

    mbl_skip_cnt #(.IDX_W(IDX_W)) u_skip (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .hit    (hit),
        .skip   (skip_cnt),
        .log_ok (log_ok)
    );

    mbl_log_bank #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .wr      (hit && log_ok),
        .wr_addr (acc_addr),
        .wr_data (acc_data),
        .rd_sel  (rd_sel),
        .count   (log_count),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // sticky fail flag, independent of the skip count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail <= 1'b0;
        end else if (start) begin
            fail <= 1'b0;
        end else if (hit) begin
            fail <= 1'b1;
        end
    end

endmodule

// File: rtl/mbl_checker.sv
module mbl_checker
    import mbl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             halt_en,
    input logic             acc_valid,
    input logic             acc_fail,
    input logic             fail,
    input logic             done,
    input logic             halted,
    input logic [CNT_W-1:0] log_count,
    input mbl_state_e       st
);

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!fail && log_count == '0 && !done));

    assert_fail_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        log_count <= CNT_W'(DEPTH));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (log_count == $past(log_count) || log_count == $past(log_count) + 1'b1));

    assert_halt_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && acc_valid && acc_fail && halt_en && !start) |=> (halted && done));

    assert_halt_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> done);

    assert_ignore_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(log_count) && $stable(fail)));

    assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !start) |=> ($stable(log_count) && $stable(fail) && $stable(st)));

endmodule

bind mbist_fail_log mbl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halt_en   (halt_en),
    .acc_valid (acc_valid),
    .acc_fail  (acc_fail),
    .fail      (fail),
    .done      (done),
    .halted    (halted),
    .log_count (log_count),
    .st        (st)
);

// File: tb/tb_mbist_fail_log.sv
module tb_mbist_fail_log;

    localparam int NACC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        halt_en = 1'b0;
    logic [15:0] skip_cnt = '0;
    logic        acc_valid = 1'b0;
    logic        acc_fail = 1'b0;
    logic        acc_last = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [15:0] acc_data = '0;
    logic [1:0]  rd_sel = '0;
    logic        fail, done, halted;
    logic [2:0]  log_count;
    logic [15:0] rd_addr, rd_data;

    int vecs = 0;
    int errs = 0;

    always #5 clk = ~clk;

    mbist_fail_log dut (
        .clk(clk), .rst_n(rst_n), .start(start), .halt_en(halt_en),
        .skip_cnt(skip_cnt), .acc_valid(acc_valid), .acc_fail(acc_fail),
        .acc_last(acc_last), .acc_addr(acc_addr), .acc_data(acc_data),
        .rd_sel(rd_sel), .fail(fail), .done(done), .halted(halted),
        .log_count(log_count), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_pass(input logic [NACC-1:0] mask, input int skip,
                            input bit hlt, input bit down);
        logic [15:0] ea [4];
        logic [15:0] ed [4];
        int  ecnt = 0;
        int  idx = 0;
        bit  efail = 0, edone = 0, ehalt = 0;
        for (int k = 0; k < 4; k++) begin ea[k] = '0; ed[k] = '0; end
        @(negedge clk);
        skip_cnt = 16'(skip);
        halt_en  = hlt;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 fail clear", 32'(fail), 0);
        chk("R1 count clear", 32'(log_count), 0);
        chk("R1 done clear", 32'(done), 0);
        for (int i = 0; i < NACC + 3; i++) begin
            int  a = down ? (NACC - 1 - (i % NACC)) : (i % NACC);
            bit  f = mask[i % NACC];
            acc_valid = 1'b1;
            acc_fail  = f;
            acc_last  = (i == NACC - 1);
            acc_addr  = 16'(a);
            acc_data  = 16'(a) * 16'h0101;
            if (!edone && f) begin
                efail = 1;
                if (idx >= skip && ecnt < 4) begin
                    ea[ecnt] = 16'(a);
                    ed[ecnt] = 16'(a) * 16'h0101;
                    ecnt++;
                end
                idx++;
                if (hlt) begin ehalt = 1; edone = 1; end
            end
            if (!edone && i == NACC - 1) edone = 1;
            @(negedge clk);
            chk("R2 fail flag", 32'(fail), 32'(efail));
            chk("R7/R8 done timing", 32'(done), 32'(edone));
            chk("R7 halted", 32'(halted), 32'(ehalt));
            chk("R9/R5 count", 32'(log_count), 32'(ecnt));
            if (i % 3 == 1) begin
                acc_valid = 1'b0;
                acc_fail  = 1'b1;
                acc_addr  = 16'hBEEF;
                acc_data  = 16'hDEAD;
                @(negedge clk);
                chk("R10 invalid fail", 32'(fail), 32'(efail));
                chk("R10 invalid count", 32'(log_count), 32'(ecnt));
            end
        end
        acc_valid = 1'b0;
        acc_fail  = 1'b0;
        acc_last  = 1'b0;
        @(negedge clk);
        chk("R5 final count", 32'(log_count), 32'(ecnt));
        for (int k = 0; k < 4; k++) begin
            rd_sel = 2'(k);
            #1;
            chk("R3/R4/R6 entry addr", 32'(rd_addr), 32'(ea[k]));
            chk("R3/R4/R6 entry data", 32'(rd_data), 32'(ed[k]));
        end
    endtask

    initial begin
        logic [NACC-1:0] masks [6];
        masks[0] = 12'h000;
        masks[1] = 12'h001;
        masks[2] = 12'h800;
        masks[3] = 12'hFFF;
        masks[4] = 12'h5A5;
        masks[5] = 12'h0C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset fail", 32'(fail), 0);
        chk("R1 reset done", 32'(done), 0);
        chk("R4 reset count", 32'(log_count), 0);
        for (int m = 0; m < 6; m++)
            for (int s = 0; s <= 6; s++)
                for (int h = 0; h < 2; h++)
                    for (int d = 0; d < 2; d++)
                        run_pass(masks[m], s, h[0], d[0]);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #1_000_000;
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule